// File: doc/BRIEF.md
# NAND Page Store with AND Programming

This block is the storage array that sits behind a NAND command sequencer. It keeps a parameterized number of erase blocks in on-chip memory. Each block is a power-of-two count of pages, and each page holds a main area followed by a spare area one thirty-second of its size. The main area is 256, 512 or 2048 bytes, chosen by parameter.

The sequencer asks for one of three actions with a single-cycle start strobe:
- **Load** streams a page out through the buffer port. It starts at a chosen column and runs to the last spare byte.
- **Program** pulls bytes in through the same port. Each incoming byte is ANDed into the stored byte, so a bit can only go from 1 to 0.
- **Erase** rounds a row down to its block and fills every byte of that block with 0xFF, spare bytes included.

Each action moves one byte per clock and ends with a one-cycle done pulse. An out-of-range request is refused at once with an error flag and leaves the memory untouched.

After reset the store sweeps the whole array to 0xFF, one byte per clock, while it reports busy.

Top module: `nand_page_store`

## Requirements
- R1: A program ANDs each supplied byte into the stored byte, so a bit once cleared stays 0 until its block is erased.
- R2: Erase (op code 2) rounds the row down to a multiple of BLOCK_PAGES. It writes 0xFF to all BLOCK_PAGES pages of that block, spare bytes included, and leaves other blocks unchanged. The done pulse arrives BLOCK_PAGES*(PAGE_BYTES+PAGE_BYTES/32)+1 cycles after the start cycle.
- R3: A page occupies PAGE_BYTES main bytes followed by PAGE_BYTES/32 spare bytes. With the defaults, a load from column 0 delivers 264 bytes.
- R4: After reset release, busy stays high for exactly as many cycles as the array has bytes. After that, every byte of every page reads 0xFF. While reset is held, done, err and bufValid are 0.
- R5: A load (op code 0) from column C asserts bufValid for the (PAGE_BYTES+PAGE_BYTES/32)-C cycles that start one cycle after the start cycle. In those cycles bufIndex steps C, C+1, … and bufRdData carries the stored byte at that column.
- R6: A request is refused when any of these holds: the row is at or above BLOCK_PAGES*NUM_BLOCKS; the column is at or beyond the page-plus-spare size for a load or program; or the op code is 3. A refused request raises done and err together in the cycle after the start cycle, produces no bufValid beat, and changes no memory byte.
- R7: done is a single-cycle pulse. It arrives in the cycle after the last byte of a transfer, with busy low. A start strobe raised while busy is ignored.
- R8: Op codes are 0 load, 1 program, 2 erase and 3 invalid.
- R9: A program (op code 1) from column C samples bufWrData in each bufValid cycle, for bufIndex C through the last spare byte. It leaves the bytes below C unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reqStart | input | 1 | Request strobe, taken only when not busy |
| reqOp | input | 2 | Operation code (R8) |
| reqRow | input | ROW_W | Page index |
| reqCol | input | COL_W | Starting column within page plus spare |
| bufWrData | input | 8 | Byte to program at bufIndex |
| busy | output | 1 | Init sweep or request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request refused, valid with done |
| bufValid | output | 1 | A load or program byte moves this cycle |
| bufIndex | output | COL_W | Column of the byte moving this cycle |
| bufRdData | output | 8 | Stored byte at bufIndex during a load |

## Verification
The assertions assume that the sequencer holds reqOp, reqRow and reqCol steady in the cycle it raises reqStart. They also assume that bufWrData is a function of bufIndex alone during a program. The bench drives every request field at the falling edge and derives bufWrData combinationally from bufIndex and a per-request seed, so both assumptions always hold.

The bench raises a start strobe in the middle of a running load to exercise the ignore rule. It always reads pages back only after done has been seen.

// File: rtl/nand_store_pkg.sv
package nand_store_pkg;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_BAD   = 2'd3
  } store_op_e;

  typedef enum logic [1:0] {
    S_INIT,
    S_IDLE,
    S_XFER,
    S_WIPE
  } store_state_e;

  // write strobes from control to datapath
  typedef struct packed {
    logic wrAnd;   // read-modify-write: mem &= bufWrData
    logic wrFill;  // write 0xFF
  } store_strobe_t;

endpackage

// File: rtl/nand_store_ctrl.sv
module nand_store_ctrl
  import nand_store_pkg::*;
#(
  parameter int PAGE_BYTES  = 256,
  parameter int BLOCK_PAGES = 8,
  parameter int NUM_BLOCKS  = 2,
  localparam int SPARE_BYTES = PAGE_BYTES / 32,
  localparam int PAGE_TOTAL  = PAGE_BYTES + SPARE_BYTES,
  localparam int NUM_PAGES   = BLOCK_PAGES * NUM_BLOCKS,
  localparam int BLOCK_BYTES = BLOCK_PAGES * PAGE_TOTAL,
  localparam int TOTAL_BYTES = NUM_PAGES * PAGE_TOTAL,
  localparam int AW          = $clog2(TOTAL_BYTES),
  localparam int COL_W       = $clog2(PAGE_TOTAL),
  localparam int ROW_W       = $clog2(NUM_PAGES) + 1,
  localparam int BP_SHIFT    = $clog2(BLOCK_PAGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqStart,
  input  logic [1:0]        reqOp,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              bufValid,
  output logic [COL_W-1:0]  bufIndex,
  output store_strobe_t     strobe,
  output logic [AW-1:0]     memAddr
);

  store_state_e    state;
  logic [AW-1:0]   ptr;
  logic [AW-1:0]   lastPtr;
  logic [COL_W-1:0] colCnt;
  logic            isProg;

  logic            reqBad;
  logic [AW-1:0]   rowBase;
  logic [AW-1:0]   blkBase;
  store_op_e       opDec;

  always_comb begin
    opDec   = store_op_e'(reqOp);
    reqBad  = (opDec == OP_BAD) ||
              (int'(reqRow) >= NUM_PAGES) ||
              ((opDec != OP_ERASE) && (int'(reqCol) >= PAGE_TOTAL));
    rowBase = AW'(reqRow) * AW'(PAGE_TOTAL);
    blkBase = AW'(reqRow >> BP_SHIFT) * AW'(BLOCK_BYTES);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_INIT;
      ptr     <= '0;
      lastPtr <= AW'(TOTAL_BYTES - 1);
      colCnt  <= '0;
      isProg  <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (state)
        S_INIT: begin
          ptr <= ptr + 1'b1;
          if (ptr == lastPtr) state <= S_IDLE;
        end
        S_IDLE: begin
          if (reqStart) begin
            if (reqBad) begin
              done <= 1'b1;
              err  <= 1'b1;
            end else if (opDec == OP_ERASE) begin
              ptr     <= blkBase;
              lastPtr <= blkBase + AW'(BLOCK_BYTES - 1);
              state   <= S_WIPE;
            end else begin
              ptr     <= rowBase + AW'(reqCol);
              lastPtr <= rowBase + AW'(PAGE_TOTAL - 1);
              colCnt  <= reqCol;
              isProg  <= (opDec == OP_PROG);
              state   <= S_XFER;
            end
          end
        end
        S_XFER: begin
          ptr    <= ptr + 1'b1;
          colCnt <= colCnt + 1'b1;
          if (ptr == lastPtr) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end
        end
        S_WIPE: begin
          ptr <= ptr + 1'b1;
          if (ptr == lastPtr) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    busy          = (state != S_IDLE);
    bufValid      = (state == S_XFER);
    bufIndex      = colCnt;
    memAddr       = ptr;
    strobe.wrAnd  = (state == S_XFER) && isProg;
    strobe.wrFill = (state == S_WIPE) || (state == S_INIT);
  end

  // R6
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  // R6
  bad_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reqStart && !busy && int'(reqRow) >= NUM_PAGES) |=> (done && err && !bufValid));

  // R5
  xfer_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bufValid |-> (int'(bufIndex) < PAGE_TOTAL));

  // R5
  xfer_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bufValid && $past(bufValid)) |-> (bufIndex == $past(bufIndex) + 1'b1));

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

// File: rtl/nand_store_dp.sv
module nand_store_dp
  import nand_store_pkg::*;
#(
  parameter int TOTAL_BYTES = 4224,
  localparam int AW = $clog2(TOTAL_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  store_strobe_t strobe,
  input  logic [AW-1:0] memAddr,
  input  logic [7:0]    wrData,
  output logic [7:0]    rdData
);

  logic [7:0] mem [TOTAL_BYTES];

  assign rdData = mem[memAddr];

  always_ff @(posedge clk) begin
    if (strobe.wrFill)      mem[memAddr] <= 8'hFF;
    else if (strobe.wrAnd)  mem[memAddr] <= mem[memAddr] & wrData;
  end

  // shadow of the previous write, kept only for the checks below
  logic          prevAnd;
  logic          prevFill;
  logic [AW-1:0] prevAddr;
  logic [7:0]    prevOld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevAnd  <= 1'b0;
      prevFill <= 1'b0;
      prevAddr <= '0;
      prevOld  <= '0;
    end else begin
      prevAnd  <= strobe.wrAnd && !strobe.wrFill;
      prevFill <= strobe.wrFill;
      prevAddr <= memAddr;
      prevOld  <= rdData;
    end
  end

  // R1
  and_only_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prevAnd |-> ((mem[prevAddr] & ~prevOld) == 8'h00));

  // R2
  fill_is_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prevFill |-> (mem[prevAddr] == 8'hFF));

endmodule

// File: rtl/nand_page_store.sv
module nand_page_store
  import nand_store_pkg::*;
#(
  parameter int PAGE_BYTES  = 256,
  parameter int BLOCK_PAGES = 8,
  parameter int NUM_BLOCKS  = 2,
  localparam int SPARE_BYTES = PAGE_BYTES / 32,
  localparam int PAGE_TOTAL  = PAGE_BYTES + SPARE_BYTES,
  localparam int NUM_PAGES   = BLOCK_PAGES * NUM_BLOCKS,
  localparam int TOTAL_BYTES = NUM_PAGES * PAGE_TOTAL,
  localparam int AW          = $clog2(TOTAL_BYTES),
  localparam int COL_W       = $clog2(PAGE_TOTAL),
  localparam int ROW_W       = $clog2(NUM_PAGES) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reqStart,
  input  logic [1:0]       reqOp,
  input  logic [ROW_W-1:0] reqRow,
  input  logic [COL_W-1:0] reqCol,
  input  logic [7:0]       bufWrData,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic             bufValid,
  output logic [COL_W-1:0] bufIndex,
  output logic [7:0]       bufRdData
);

  store_strobe_t strobe;
  logic [AW-1:0] memAddr;

  nand_store_ctrl #(
    .PAGE_BYTES (PAGE_BYTES),
    .BLOCK_PAGES(BLOCK_PAGES),
    .NUM_BLOCKS (NUM_BLOCKS)
  ) i_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .reqStart(reqStart),
    .reqOp   (reqOp),
    .reqRow  (reqRow),
    .reqCol  (reqCol),
    .busy    (busy),
    .done    (done),
    .err     (err),
    .bufValid(bufValid),
    .bufIndex(bufIndex),
    .strobe  (strobe),
    .memAddr (memAddr)
  );

  nand_store_dp #(
    .TOTAL_BYTES(TOTAL_BYTES)
  ) i_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (strobe),
    .memAddr(memAddr),
    .wrData (bufWrData),
    .rdData (bufRdData)
  );

endmodule

// File: tb/test_nand_page_store.sv
`timescale 1ns/1ps
module test_nand_page_store;

  localparam int PB     = 256;
  localparam int BP     = 8;
  localparam int NB     = 2;
  localparam int PT     = PB + PB / 32;
  localparam int NP     = BP * NB;
  localparam int TOTAL  = NP * PT;
  localparam int COL_W  = $clog2(PT);
  localparam int ROW_W  = $clog2(NP) + 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             reqStart = 1'b0;
  logic [1:0]       reqOp = '0;
  logic [ROW_W-1:0] reqRow = '0;
  logic [COL_W-1:0] reqCol = '0;
  logic [7:0]       bufWrData;
  logic             busy, done, err, bufValid;
  logic [COL_W-1:0] bufIndex;
  logic [7:0]       bufRdData;
  logic [7:0]       curSeed = '0;

  always #2 clk = ~clk;  // 250 MHz

  nand_page_store #(.PAGE_BYTES(PB), .BLOCK_PAGES(BP), .NUM_BLOCKS(NB)) i_nand_page_store (
    .clk(clk), .rst_n(rst_n), .reqStart(reqStart), .reqOp(reqOp),
    .reqRow(reqRow), .reqCol(reqCol), .bufWrData(bufWrData),
    .busy(busy), .done(done), .err(err), .bufValid(bufValid),
    .bufIndex(bufIndex), .bufRdData(bufRdData)
  );

  function automatic logic [7:0] pat(input logic [7:0] seed, input int idx);
    return 8'((idx * 7 + int'(seed) * 29) ^ (int'(seed) << 2) ^ (idx >> 3));
  endfunction

  always_comb bufWrData = pat(curSeed, int'(bufIndex));

  logic [7:0] model [TOTAL];
  int tests = 0;
  int fails = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // runs one request; pokeAt>0 raises a stray start at that beat (R7)
  task automatic runOp(input int op, input int row, input int col,
                       input logic [7:0] seed, input string req, input int pokeAt);
    bit bad;
    int beats, cyc, badIdx, mism, expCyc, dones;
    bad = (op == 3) || (row >= NP) || (op != 2 && col >= PT);
    beats = 0; cyc = 0; badIdx = 0; mism = 0; dones = 0;
    @(negedge clk);
    reqOp = 2'(op); reqRow = ROW_W'(row); reqCol = COL_W'(col);
    curSeed = seed; reqStart = 1'b1;
    @(negedge clk);
    reqStart = 1'b0;
    cyc = 1;
    forever begin
      reqStart = 1'b0;
      if (bufValid) begin
        if (int'(bufIndex) != col + beats) badIdx++;
        if (op == 0 && bufRdData != model[row * PT + col + beats]) mism++;
        beats++;
        if (pokeAt > 0 && beats == pokeAt) begin
          reqStart = 1'b1; reqOp = 2'd2; reqRow = '0;  // stray erase while busy
        end
      end
      if (done) break;
      @(negedge clk);
      cyc++;
      if (cyc > 20000) break;
    end
    dones = 1;
    check(err == bad, "R6", {req, " err flag"}, err, bad);
    expCyc = bad ? 1 : (op == 2 ? BP * PT + 1 : PT - col + 1);
    check(cyc == expCyc, bad ? "R6" : (op == 2 ? "R2" : "R7"), {req, " cycles to done"}, cyc, expCyc);
    if (!bad && op != 2) begin
      check(beats == PT - col, "R5", {req, " beat count"}, beats, PT - col);
      check(badIdx == 0, "R5", {req, " index sequence errors"}, badIdx, 0);
    end
    if (bad) check(beats == 0, "R6", {req, " beats on refused request"}, beats, 0);
    if (op == 0 && !bad) check(mism == 0, "R5", {req, " load data mismatches"}, mism, 0);
    @(negedge clk);
    check(done == 1'b0, "R7", {req, " done lasts one cycle"}, done, 0);
    if (done) dones++;
    if (!bad && op == 1)
      for (int i = col; i < PT; i++) model[row * PT + i] &= pat(seed, i);
    if (!bad && op == 2)
      for (int i = (row / BP) * BP * PT; i < ((row / BP) + 1) * BP * PT; i++) model[i] = 8'hFF;
  endtask

  task automatic readback(input int row, input string req);
    runOp(0, row, 0, 8'h00, req, 0);
  endtask

  // op, row, col, seed
  localparam logic [23:0] VECS [12] = '{
    {2'd1, 5'd0,  9'd0,   8'd1},
    {2'd1, 5'd0,  9'd0,   8'd2},
    {2'd1, 5'd3,  9'd100, 8'd3},
    {2'd1, 5'd9,  9'd0,   8'd4},
    {2'd1, 5'd15, 9'd250, 8'd5},
    {2'd2, 5'd10, 9'd0,   8'd0},
    {2'd1, 5'd9,  9'd263, 8'd6},
    {2'd0, 5'd3,  9'd200, 8'd0},
    {2'd1, 5'd16, 9'd0,   8'd7},
    {2'd0, 5'd2,  9'd264, 8'd0},
    {2'd3, 5'd1,  9'd0,   8'd8},
    {2'd2, 5'd20, 9'd0,   8'd0}
  };

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    int k;
    for (int i = 0; i < TOTAL; i++) model[i] = 8'hFF;
    repeat (2) @(negedge clk);
    // R4: outputs quiet under reset
    check(done == 0 && err == 0 && bufValid == 0, "R4", "outputs in reset",
          {done, err, bufValid}, 0);
    rst_n = 1'b1;
    k = 0;
    do begin @(negedge clk); k++; end while (busy && k < 10000);
    check(k == TOTAL, "R4", "init sweep length", k, TOTAL);
    readback(0, "R4 R3 page0 blank");
    readback(NP - 1, "R4 last page blank");

    foreach (VECS[v]) begin
      runOp(int'(VECS[v][23:22]), int'(VECS[v][21:17]), int'(VECS[v][16:8]),
            VECS[v][7:0], $sformatf("R8 vec%0d", v), 0);
      readback(0,  "R1 page0");
      readback(3,  "R9 page3");
      readback(9,  "R2 page9");
      readback(15, "R2 page15");
    end

    // R7: stray start during a load is ignored; memory unchanged
    runOp(0, 3, 0, 8'h00, "R7 stray start", 7);
    readback(0, "R7 page0 after stray start");
    readback(3, "R7 page3 after stray start");

    // R2: erase block 0 via a non-aligned row; block 1 untouched
    runOp(1, 12, 0, 8'h5A, "R1 block1 program", 0);
    runOp(2, 5, 0, 8'h00, "R2 erase row5", 0);
    readback(0, "R2 page0 erased");
    readback(7, "R2 page7 erased");
    readback(12, "R2 page12 kept");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule